// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block carries out one clause-22 PHY register access at a time over the two-wire management interface (MDC clock, MDIO data). A host with a register map writes a single 32-bit command word. The word holds the start code, opcode, PHY address, register address, turnaround pattern and 16 data bits. Accepting the word launches one serial frame. The block first sends a preamble of 32 ones, then shifts the word out MSB first. For a read, it releases the data line for the turnaround and data phases and captures the PHY's reply into the low half of the same word. The host polls the idle output to see when the access has finished.

MDC is produced by dividing the system clock by 8, 16, 32 or 64. The host picks the ratio so that MDC stays at or below 2.5 MHz: 64 above 80 MHz, 32 above 40 MHz, 16 above 20 MHz, and 8 otherwise. A management enable input gates the whole interface. Frames start only while it is high, and dropping it stops a frame in progress.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0 and cmd_word is 0.
- R2: During a frame, one MDC period lasts (8 << div_sel) system clock cycles (div_sel 0..3 gives 8, 16, 32, 64), and MDC is high for exactly half of it. The ratio is taken when the frame starts.
- R3: A cmd_wr pulse starts a frame only when mgmt_en is 1 and idle is 1. With mgmt_en at 0 it has no effect on idle or cmd_word.
- R4: The command word layout is [31:30] start 01, [29:28] opcode, [27:23] PHY address, [22:18] register address, [17:16] turnaround 10, [15:0] data. A frame puts 32 ones on MDIO, then word bits 31 down to 0, one bit per MDC period. idle stays low for exactly 64 × divisor cycles.
- R5: While a frame runs, mdio_o changes only in the cycle in which MDC falls. MDIO is thus driven on the falling edge and sampled by the PHY on the rising edge.
- R6: When opcode [29:28] is 10 (read), mdio_oe is low for the last 18 bit periods (turnaround and data). Any other opcode is sent as a write with mdio_oe high for all 64 bit periods.
- R7: When a read completes, cmd_word[15:0] holds the 16 bits sampled on mdio_i at the last 16 MDC rising edges, MSB first, and cmd_word[31:16] is unchanged. A write leaves cmd_word equal to the word that was written.
- R8: A cmd_wr pulse while a frame is in progress is ignored. The running frame, its result and the PHY access it performs are unchanged.
- R9: If mgmt_en drops during a frame, the frame stops. On the next cycle idle is 1, mdc is 0 and mdio_oe is 0, and the next frame runs normally.
- R10: While idle is 1, mdc is 0 and mdio_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_en | input | 1 | Management interface enable |
| div_sel | input | 2 | MDC divisor select: 0=8, 1=16, 2=32, 3=64 |
| cmd_wr | input | 1 | One-cycle strobe that writes the command word |
| cmd_wdata | input | 32 | Command word written by the host |
| cmd_word | output | 32 | Current command word; holds read data after a read |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable; low means released |
| mdio_i | input | 1 | MDIO input data from the pad |

## Verification
The assertions assume that div_sel and the command word come from a host that only changes them while idle. They also assume a PHY that changes mdio_i only after an MDC falling edge, so it is stable at the sampling edge. The bench keeps to this: a PHY responder updates its drive on the MDC fall and pulls the line high when it is not addressed. The bench holds div_sel steady through each frame and deliberately breaks only the enable and busy-write rules, in the directed abort and overlap cases.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int WORD_BITS  = 32;
    localparam int FRAME_BITS = PRE_BITS + WORD_BITS;
    localparam int DATA_BITS  = 16;
    localparam int TA_BITS    = 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int WIDX_W     = $clog2(WORD_BITS);
    localparam int TA_FIRST   = FRAME_BITS - DATA_BITS - TA_BITS;
    localparam int DATA_FIRST = FRAME_BITS - DATA_BITS;
    localparam int OP_HI      = WORD_BITS - 3;
    localparam logic [1:0] OP_READ = 2'b10;

    typedef struct packed {
        logic                 busy;
        logic                 rd;
        logic [IDX_W-1:0]     idx;
        logic [WORD_BITS-1:0] word;
        logic                 mdo;
        logic                 oe;
    } shift_st_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int BASE_LOG2 = 3,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
        logic [SEL_W-1:0] sel;
    } clk_st_t;

    clk_st_t cs_q, cs_d;
    logic [CNT_W:0] full_len;
    logic [CNT_W:0] half_len;

    always_comb begin
        full_len  = (CNT_W+1)'(1) << (BASE_LOG2 + int'(cs_q.sel));
        half_len  = full_len >> 1;
        rise_tick = run && ({1'b0, cs_q.cnt} == half_len - 1'b1);
        fall_tick = run && ({1'b0, cs_q.cnt} == full_len - 1'b1);
        cs_d = cs_q;
        if (!run) begin
            cs_d.cnt = '0;
            cs_d.mdc = 1'b0;
            cs_d.sel = sel;
        end else begin
            cs_d.cnt = fall_tick ? '0 : cs_q.cnt + 1'b1;
            if (rise_tick)
                cs_d.mdc = 1'b1;
            else if (fall_tick)
                cs_d.mdc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cs_q <= '0;
        else
            cs_q <= cs_d;
    end

    assign mdc = cs_q.mdc;

    // checker: length of the current high phase of MDC
    logic [CNT_W:0] hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_run_q <= '0;
        else if (cs_q.mdc)
            hi_run_q <= hi_run_q + 1'b1;
        else
            hi_run_q <= '0;
    end

    assert_mdc_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.mdc |-> (hi_run_q < half_len));
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 start,
    input  logic [WORD_BITS-1:0] cmd_in,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic [WORD_BITS-1:0] word,
    output logic                 mdo,
    output logic                 oe
);
    shift_st_t cs_q, cs_d;
    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] nidx;
    logic [IDX_W-1:0] npos;

    always_comb begin
        cs_d = cs_q;
        pos  = IDX_W'(FRAME_BITS - 1) - cs_q.idx;
        nidx = cs_q.idx + 1'b1;
        npos = IDX_W'(FRAME_BITS - 1) - nidx;
        if (!cs_q.busy) begin
            if (start && en) begin
                cs_d.busy = 1'b1;
                cs_d.rd   = (cmd_in[OP_HI -: 2] == OP_READ);
                cs_d.idx  = '0;
                cs_d.word = cmd_in;
                cs_d.mdo  = 1'b1;
                cs_d.oe   = 1'b1;
            end
        end else if (!en) begin
            cs_d.busy = 1'b0;
            cs_d.oe   = 1'b0;
            cs_d.mdo  = 1'b1;
        end else begin
            if (rise_tick && cs_q.rd && (cs_q.idx >= IDX_W'(DATA_FIRST)))
                cs_d.word[pos[WIDX_W-1:0]] = mdio_i;
            if (fall_tick) begin
                if (cs_q.idx == IDX_W'(FRAME_BITS - 1)) begin
                    cs_d.busy = 1'b0;
                    cs_d.oe   = 1'b0;
                    cs_d.mdo  = 1'b1;
                end else begin
                    cs_d.idx = nidx;
                    cs_d.mdo = (nidx < IDX_W'(PRE_BITS)) ? 1'b1
                                                         : cs_q.word[npos[WIDX_W-1:0]];
                    cs_d.oe  = !(cs_q.rd && (nidx >= IDX_W'(TA_FIRST)));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= '0;
            cs_q.mdo <= 1'b1;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign busy = cs_q.busy;
    assign word = cs_q.word;
    assign mdo  = cs_q.mdo;
    assign oe   = cs_q.oe;

    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.busy && $past(cs_q.busy)) |-> $stable(cs_q.word[WORD_BITS-1:DATA_BITS]));

    assert_mdo_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.busy && $past(cs_q.busy) && !$past(fall_tick)) |-> $stable(cs_q.mdo));

    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.busy && cs_q.rd && (cs_q.idx >= IDX_W'(TA_FIRST))) |-> !cs_q.oe);

    assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.busy && !cs_q.rd) |-> cs_q.oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mgmt_en,
    input  logic [1:0]  div_sel,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_word,
    output logic        idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic busy;
    logic rise_tick;
    logic fall_tick;
    logic clk_run;

    assign clk_run = busy && mgmt_en;

    mdio_clkgen #(
        .BASE_LOG2 (3),
        .SEL_W     (2)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (clk_run),
        .sel       (div_sel),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mgmt_en),
        .start     (cmd_wr),
        .cmd_in    (cmd_wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .word      (cmd_word),
        .mdo       (mdio_o),
        .oe        (mdio_oe)
    );

    assign idle = !busy;

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));

    assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_en |=> idle);

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mgmt_en) && !idle) |=> (idle && !mdc && !mdio_oe));
endmodule

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mgmt_en;
    logic [1:0]  div_sel;
    logic        cmd_wr;
    logic [31:0] cmd_wdata;
    logic [31:0] cmd_word;
    logic        idle;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        phy_drv;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mgmt_en   (mgmt_en),
        .div_sel   (div_sel),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .cmd_word  (cmd_word),
        .idle      (idle),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (phy_drv)
    );

    localparam logic [4:0] PHY_ADR = 5'd3;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] phy_mem [32];
    logic [15:0] exp_mem [32];

    // PHY responder and line monitor, evaluated on the falling system clock edge
    int          rises = 0;
    int          oelow = 0;
    int          last_rise = 0;
    int          last_period = 0;
    int          r5_viol = 0;
    logic [63:0] bitlog = '0;
    logic        rd_hit = 1'b0;
    logic [4:0]  rd_reg = '0;
    logic        mdc_prev = 1'b0;
    logic        idle_prev = 1'b1;
    logic        mdo_prev = 1'b1;

    always @(negedge clk) begin
        logic rise_now;
        logic fall_now;
        cyc++;
        rise_now = mdc && !mdc_prev;
        fall_now = !mdc && mdc_prev;
        if (idle) begin
            rises   = 0;
            rd_hit  = 1'b0;
            phy_drv = 1'b1;
        end else begin
            if (!idle_prev && (mdio_o !== mdo_prev) && !fall_now)
                r5_viol++;
            if (rise_now) begin
                if (rises == 0) begin
                    oelow  = 0;
                    bitlog = '0;
                end
                bitlog = {bitlog[62:0], mdio_o};
                if (!mdio_oe) oelow++;
                if (rises > 0) last_period = cyc - last_rise;
                last_rise = cyc;
                if (rises == 45) begin
                    rd_hit = (bitlog[11:10] == 2'b10) && (bitlog[9:5] == PHY_ADR);
                    rd_reg = bitlog[4:0];
                end
                if (rises == 63 && bitlog[29:28] == 2'b01 && bitlog[27:23] == PHY_ADR)
                    phy_mem[bitlog[22:18]] = bitlog[15:0];
                rises++;
            end
            if (fall_now) begin
                if (rd_hit && rises == 47)
                    phy_drv = 1'b0;
                else if (rd_hit && rises >= 48 && rises <= 63)
                    phy_drv = phy_mem[rd_reg][63 - rises];
                else
                    phy_drv = 1'b1;
            end
        end
        mdc_prev  = mdc;
        idle_prev = idle;
        mdo_prev  = mdio_o;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] w);
        if (w[29:28] != 2'b10) return w;
        if (w[27:23] == PHY_ADR) return {w[31:16], exp_mem[w[22:18]]};
        return {w[31:16], 16'hFFFF};
    endfunction

    task automatic pulse_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_wdata = w;
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr    = 1'b0;
    endtask

    task automatic run_frame(input logic [31:0] w, input logic [1:0] sel);
        int dur;
        int dv;
        logic [31:0] ew;
        bit is_rd;
        dv    = 8 << sel;
        ew    = exp_word(w);
        is_rd = (w[29:28] == 2'b10);
        @(negedge clk);
        div_sel = sel;
        pulse_cmd(w);
        dur = 0;
        while (!idle) begin
            @(negedge clk);
            dur++;
        end
        chk(dur == 64 * dv, "R4 frame length", 64'(dur), 64'(64 * dv));
        chk(last_period == dv, "R2 mdc period", 64'(last_period), 64'(dv));
        chk(cmd_word == ew, "R7 result word", 64'(cmd_word), 64'(ew));
        chk(oelow == (is_rd ? 18 : 0), "R6 released bit periods", 64'(oelow),
            64'(is_rd ? 18 : 0));
        if (!is_rd) begin
            chk(bitlog == {32'hFFFF_FFFF, w}, "R4 serial bits", bitlog, {32'hFFFF_FFFF, w});
            if (w[27:23] == PHY_ADR) exp_mem[w[22:18]] = w[15:0];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [31:0] w2;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) begin
            phy_mem[i] = 16'(i * 16'h0123) ^ 16'h5A00;
            exp_mem[i] = phy_mem[i];
        end
        rst_n = 1'b0; mgmt_en = 1'b0; div_sel = 2'd0; cmd_wr = 1'b0; cmd_wdata = '0;
        phy_drv = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(idle == 1'b1, "R1 idle", 64'(idle), 64'd1);
        chk(mdc == 1'b0, "R1 mdc", 64'(mdc), 64'd0);
        chk(mdio_oe == 1'b0, "R1 oe", 64'(mdio_oe), 64'd0);
        chk(cmd_word == 32'd0, "R1 word", 64'(cmd_word), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: command ignored while the enable is low; R10 idle is quiet
        pulse_cmd(mk(2'b01, PHY_ADR, 5'd1, 16'hBEEF));
        begin
            bit stayed = 1'b1;
            bit quiet = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!idle) stayed = 1'b0;
                if (mdc || mdio_oe) quiet = 1'b0;
            end
            chk(stayed, "R3 no frame when disabled", 64'(stayed), 64'd1);
            chk(cmd_word == 32'd0, "R3 word untouched", 64'(cmd_word), 64'd0);
            chk(quiet, "R10 idle lines quiet", 64'(quiet), 64'd1);
        end
        mgmt_en = 1'b1;

        // directed: each divisor, writes and reads
        run_frame(mk(2'b01, PHY_ADR, 5'd5, 16'hA55A), 2'd0);
        run_frame(mk(2'b10, PHY_ADR, 5'd5, 16'h0000), 2'd1);
        run_frame(mk(2'b10, PHY_ADR, 5'd0, 16'h1234), 2'd2);
        run_frame(mk(2'b01, PHY_ADR, 5'd31, 16'hFFFF), 2'd3);
        run_frame(mk(2'b10, PHY_ADR, 5'd31, 16'h0000), 2'd0);
        // read from an absent PHY returns the pulled-up line (R7)
        run_frame(mk(2'b10, 5'd17, 5'd2, 16'h0000), 2'd0);

        // R8: second command during a frame is ignored
        w  = mk(2'b10, PHY_ADR, 5'd7, 16'h0000);
        w2 = mk(2'b01, PHY_ADR, 5'd7, 16'h0BAD);
        div_sel = 2'd0;
        pulse_cmd(w);
        repeat (100) @(negedge clk);
        pulse_cmd(w2);
        chk(idle == 1'b0, "R8 frame keeps running", 64'(idle), 64'd0);
        while (!idle) @(negedge clk);
        chk(cmd_word == exp_word(w), "R8 result from first command", 64'(cmd_word),
            64'(exp_word(w)));
        run_frame(mk(2'b10, PHY_ADR, 5'd7, 16'h0000), 2'd0);

        // R9: enable dropped mid-frame
        w = mk(2'b01, 5'd20, 5'd9, 16'h7777);
        pulse_cmd(w);
        repeat (100) @(negedge clk);
        mgmt_en = 1'b0;
        @(negedge clk);
        chk(idle == 1'b1, "R9 abort idle", 64'(idle), 64'd1);
        chk(mdc == 1'b0, "R9 abort mdc", 64'(mdc), 64'd0);
        chk(mdio_oe == 1'b0, "R9 abort oe", 64'(mdio_oe), 64'd0);
        chk(cmd_word == w, "R9 word kept", 64'(cmd_word), 64'(w));
        @(negedge clk);
        mgmt_en = 1'b1;
        run_frame(mk(2'b10, PHY_ADR, 5'd9, 16'h0000), 2'd1);

        // constrained random frames
        for (int k = 0; k < 30; k++) begin
            logic [1:0] s;
            logic [1:0] op;
            logic [4:0] pa;
            s  = 2'($urandom_range(0, 3));
            op = ($urandom_range(0, 1) == 0) ? 2'b10 : 2'b01;
            pa = ($urandom_range(0, 4) != 0) ? PHY_ADR : 5'($urandom_range(4, 31));
            run_frame(mk(op, pa, 5'($urandom), 16'($urandom)), s);
        end

        chk(r5_viol == 0, "R5 mdio changes only at mdc fall", 64'(r5_viol), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule